// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to 23 interrupt sources and turns them into interrupt requests for a processor. Each source is a single wire. It can be set to react to a rising edge, a falling edge or both. Software can also raise any line by writing a trigger bit. A line that fires while its mask bit is enabled latches a pending bit. The pending bit stays set until software clears it by writing 1 to it.

The pending lines are folded onto 14 request outputs. The low lines have private outputs. Two middle groups share one output each, and the upper lines have private outputs again. Software programs the block through a 32-bit register port with a write strobe and a combinational read. The register offsets are 0x00 mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger and 0x14 pending.

The line inputs must already be synchronous to `clk`. An edge is found by comparing each input with a copy registered on the previous clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and every `irq_out` bit is 0.
- R2: A 0-to-1 change on `line_in[i]` fires line i when its rising-select bit (0x08) is 1. A 1-to-0 change fires it when its falling-select bit (0x0C) is 1. The pending bit is visible right after the clock edge that samples the change.
- R3: A fired line sets its pending bit (0x14) only when its mask bit (0x00) is 1.
- R4: Writing 1 to a software-trigger bit (0x10) that is 0 sets the bit and fires the line. Writing 1 to a bit that is already 1, or writing 0, fires nothing.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: When a pending bit drops from 1 to 0, the software-trigger bit of that line is cleared in the same cycle.
- R7: Writing a rising-select or falling-select bit with a value different from its current value clears that line's pending bit.
- R8: `irq_out[i]` = pending[i] for lines 0..4. `irq_out[5]` = OR of lines 5..9. `irq_out[6]` = OR of lines 10..15. `irq_out[7+k]` = pending[16+k] for k = 0..6.
- R9: Writes to the event mask (0x04) change no register and no output. The event mask always reads 0.
- R10: Bits 31..23 of every register read 0. Writes to those bits are ignored.
- R11: A line that fires in the same cycle that a write clears its pending bit leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| line_in | input | 23 | Synchronous interrupt source per line |
| irq_out | output | 14 | Interrupt requests after folding |

## Verification
A wrong pending bit appears on `irq_out` right after the clock edge that produced it. On a shared output, however, it stays hidden while another line of the same group is pending, so the bench reads back the pending register after every step. A software-trigger bit that failed to clear shows up only at the next software write to that line, which then fails to fire. The directed cases therefore replay that write after each clear. A stale registered input copy shows up as a spurious or missing pending bit on the next input toggle.

// File: rtl/exti_pkg.sv
// Shared definitions for the interrupt line controller.
// Assumes byte addressing with word-aligned registers.
package exti_pkg;

    typedef enum logic [2:0] {
        SEL_MASK = 3'd0,
        SEL_EVT  = 3'd1,
        SEL_RISE = 3'd2,
        SEL_FALL = 3'd3,
        SEL_SWT  = 3'd4,
        SEL_PEND = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    // Request output that a given line folds onto.
    function automatic int line_irq(input int ln);
        if (ln < 5)       return ln;
        else if (ln < 10) return 5;
        else if (ln < 16) return 6;
        else              return ln - 9;
    endfunction

    // Number of request outputs needed for n lines.
    function automatic int irq_count(input int n);
        return line_irq(n - 1) + 1;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
// Edge detector: keeps a registered copy of each line and flags selected
// rising or falling edges. Assumes the inputs are already synchronous.
module irq_edge_det #(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] rise_sel,
    input  logic [NUM_LINES-1:0] fall_sel,
    output logic [NUM_LINES-1:0] hw_trig
);
    logic [NUM_LINES-1:0] line_q;

    // Holds the previous-cycle value of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_in;
    end

    // Fires on a selected transition against the stored copy.
    always_comb begin
        hw_trig = (line_in & ~line_q & rise_sel) | (~line_in & line_q & fall_sel);
    end

    AST_TRIG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_trig & ~(line_in ^ line_q)) == '0)); // R2
endmodule

// File: rtl/irq_line_regs.sv
// Per-line register bank: mask, edge selects, software trigger and pending.
// Set of pending wins over any clear in the same cycle.
module irq_line_regs
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [NUM_LINES-1:0] wr_bits,
    input  logic [NUM_LINES-1:0] hw_trig,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] rise_q,
    output logic [NUM_LINES-1:0] fall_q,
    output logic [NUM_LINES-1:0] swt_q,
    output logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] sw_fire, set_p, clr_p, pend_d, swt_d, pend_fall;

    // Next-state computation for pending and software trigger.
    always_comb begin
        sw_fire = (wr_en && sel == SEL_SWT) ? (wr_bits & ~swt_q) : '0;
        set_p   = (hw_trig | sw_fire) & mask_q;
        clr_p   = '0;
        if (wr_en && sel == SEL_PEND) clr_p = wr_bits;
        if (wr_en && sel == SEL_RISE) clr_p = wr_bits ^ rise_q;
        if (wr_en && sel == SEL_FALL) clr_p = wr_bits ^ fall_q;
        pend_d    = set_p | (pend_q & ~clr_p);
        pend_fall = pend_q & ~pend_d;
        swt_d     = (swt_q | sw_fire) & ~pend_fall;
    end

    // Configuration registers written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_MASK) mask_q <= wr_bits;
            if (sel == SEL_RISE) rise_q <= wr_bits;
            if (sel == SEL_FALL) fall_q <= wr_bits;
        end
    end

    // Status registers updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            swt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            swt_q  <= swt_d;
        end
    end

    AST_SWT_CLEARED_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(pend_q) & ~pend_q) & swt_q)) == '0)); // R6
    AST_MASK_GATES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~$past(pend_q) & pend_q & ~$past(mask_q))) == '0)); // R3
    AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RISE) |=>
        (((($past(wr_bits) ^ $past(rise_q)) & ~$past(hw_trig) & pend_q)) == '0)); // R7
    AST_EVT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EVT) |=>
        ($stable(mask_q) && $stable(rise_q) && $stable(fall_q))); // R9
endmodule

// File: rtl/irq_route.sv
// Folds pending lines onto request outputs using the fixed line map.
// Purely combinational.
module irq_route
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 23,
    parameter int NUM_IRQ   = irq_count(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_IRQ-1:0]   irq
);
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        logic [NUM_LINES-1:0] hit;
        // Selects the pending lines that belong to output k.
        always_comb begin
            for (int i = 0; i < NUM_LINES; i++)
                hit[i] = pend[i] && (line_irq(i) == k);
        end
        assign irq[k] = |hit;
    end

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq == '0)); // R8
    AST_IRQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq) <= $countones(pend))); // R8
endmodule

// File: rtl/ext_irq_ctrl.sv
// Top of the interrupt line controller: address decode, read mux and the
// three sub-blocks. Assumes line inputs are synchronous to clk.
module ext_irq_ctrl
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 23,
    parameter int ADDR_W    = 8,
    parameter int NUM_IRQ   = irq_count(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_IRQ-1:0]   irq_out
);
    localparam int PAD = 32 - NUM_LINES;

    reg_sel_e             sel;
    logic [NUM_LINES-1:0] hw_trig, mask_q, rise_q, fall_q, swt_q, pend_q, rd_bits;

    // Decodes the word address into a register select.
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00 && addr[ADDR_W-1:5] == '0 && addr[4:2] <= 3'd5)
            sel = reg_sel_e'(addr[4:2]);
    end

    // Read mux; the event mask holds no state and reads 0.
    always_comb begin
        case (sel)
            SEL_MASK: rd_bits = mask_q;
            SEL_RISE: rd_bits = rise_q;
            SEL_FALL: rd_bits = fall_q;
            SEL_SWT:  rd_bits = swt_q;
            SEL_PEND: rd_bits = pend_q;
            default:  rd_bits = '0;
        endcase
        rdata = {{PAD{1'b0}}, rd_bits};
    end

    irq_edge_det #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .rise_sel(rise_q), .fall_sel(fall_q), .hw_trig(hw_trig));

    irq_line_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
        .wr_bits(wdata[NUM_LINES-1:0]), .hw_trig(hw_trig),
        .mask_q(mask_q), .rise_q(rise_q), .fall_q(fall_q),
        .swt_q(swt_q), .pend_q(pend_q));

    irq_route #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_route (
        .clk(clk), .rst_n(rst_n), .pend(pend_q), .irq(irq_out));

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[31:NUM_LINES] == '0)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0)); // R1
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 23;

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [N-1:0] line_in = 0;
    logic [13:0] irq_out;
    int errors = 0, checks = 0;
    bit done = 0;

    logic [N-1:0] m_mask, m_rise, m_fall, m_swt, m_pend, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .line_in(line_in), .irq_out(irq_out));

    function automatic logic [13:0] exp_irq(input logic [N-1:0] p);
        logic [13:0] r;
        r[4:0]  = p[4:0];
        r[5]    = |p[9:5];
        r[6]    = |p[15:10];
        r[13:7] = p[22:16];
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(rdata, exp, req);
    endtask

    task automatic chk_all(input string req);
        rd_chk(8'h00, {9'b0, m_mask}, req);
        rd_chk(8'h04, 32'h0, req);
        rd_chk(8'h08, {9'b0, m_rise}, req);
        rd_chk(8'h0C, {9'b0, m_fall}, req);
        rd_chk(8'h10, {9'b0, m_swt}, req);
        rd_chk(8'h14, {9'b0, m_pend}, req);
    endtask

    // One clock: drive, model the spec, compare outputs after the edge.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [N-1:0] lin, input string req);
        logic [N-1:0] wb, hw, fire, clr, pn, fall;
        wr_en = we; addr = a; wdata = d; line_in = lin;
        wb   = d[N-1:0];
        hw   = (lin & ~m_prev & m_rise) | (~lin & m_prev & m_fall);
        fire = (we && a == 8'h10) ? (wb & ~m_swt) : '0;
        clr  = '0;
        if (we && a == 8'h14) clr = wb;
        if (we && a == 8'h08) clr = wb ^ m_rise;
        if (we && a == 8'h0C) clr = wb ^ m_fall;
        pn   = ((hw | fire) & m_mask) | (m_pend & ~clr);
        fall = m_pend & ~pn;
        @(posedge clk);
        #1;
        m_swt  = (m_swt | fire) & ~fall;
        m_pend = pn;
        m_prev = lin;
        if (we && a == 8'h00) m_mask = wb;
        if (we && a == 8'h08) m_rise = wb;
        if (we && a == 8'h0C) m_fall = wb;
        wr_en = 0;
        chk({18'b0, irq_out}, {18'b0, exp_irq(m_pend)}, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_mask = 0; m_rise = 0; m_fall = 0; m_swt = 0; m_pend = 0; m_prev = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk({18'b0, irq_out}, 32'h0, "R1");
        chk_all("R1");

        // R10: upper bits ignored
        step(1, 8'h00, 32'hFFFF_FFFF, '0, "R10");
        rd_chk(8'h00, 32'h007F_FFFF, "R10");
        // R2 rising on line 0
        step(1, 8'h08, 32'h0000_0001, '0, "R2");
        step(0, 0, 0, 23'h1, "R2");
        chk({31'b0, irq_out[0]}, 32'h1, "R2");
        chk_all("R2");
        // R5: write 0 keeps, write 1 clears
        step(1, 8'h14, 32'h0, 23'h1, "R5");
        chk({9'b0, m_pend}, 32'h1, "R5");
        step(1, 8'h14, 32'h1, 23'h1, "R5");
        chk({31'b0, irq_out[0]}, 32'h0, "R5");
        // R2 falling on line 20 (irq 11)
        step(1, 8'h0C, 32'h0010_0000, 23'h1, "R2");
        step(0, 0, 0, 23'h10_0001, "R2");
        step(0, 0, 0, 23'h00_0001, "R2");
        chk({31'b0, irq_out[11]}, 32'h1, "R2");
        // R7: changing fall select clears pending
        step(1, 8'h0C, 32'h0, 23'h1, "R7");
        chk({31'b0, irq_out[11]}, 32'h0, "R7");
        // R3: masked line does not set pending
        step(1, 8'h00, 32'h0, 23'h1, "R3");
        step(0, 0, 0, 23'h0, "R3");
        step(1, 8'h08, 32'h0000_0000, 23'h0, "R3");
        step(1, 8'h08, 32'h0000_0001, 23'h0, "R3");
        step(0, 0, 0, 23'h1, "R3");
        chk({9'b0, m_pend}, 32'h0, "R3");
        chk_all("R3");
        // R4: software trigger while masked sets swt only; rewrite does not fire
        step(1, 8'h10, 32'h0000_0040, 23'h1, "R4");
        step(1, 8'h00, 32'h007F_FFFF, 23'h1, "R4");
        step(1, 8'h10, 32'h0000_0040, 23'h1, "R4");
        rd_chk(8'h14, 32'h0, "R4");
        rd_chk(8'h10, 32'h40, "R4");
        // R6: swt clears with pending, then a rewrite fires again
        step(1, 8'h10, 32'h0000_0080, 23'h1, "R6");
        chk({31'b0, irq_out[5]}, 32'h1, "R8");
        step(1, 8'h14, 32'h0000_0080, 23'h1, "R6");
        rd_chk(8'h10, 32'h40, "R6");
        step(1, 8'h10, 32'h0000_0080, 23'h1, "R6");
        rd_chk(8'h14, 32'h80, "R6");
        // R8: shared output 6 from two lines
        step(1, 8'h10, 32'h0000_8400, 23'h1, "R8");
        step(1, 8'h14, 32'h0000_0400, 23'h1, "R8");
        chk({31'b0, irq_out[6]}, 32'h1, "R8");
        // R11: trigger beats clear in the same cycle
        step(1, 8'h08, 32'h0000_0003, 23'h1, "R11");
        step(1, 8'h14, 32'h0000_0002, 23'h1, "R11");
        step(1, 8'h14, 32'h0000_0002, 23'h3, "R11");
        rd_chk(8'h14, {9'b0, m_pend}, "R11");
        chk({31'b0, irq_out[1]}, 32'h1, "R11");
        // R9: event mask write has no effect
        step(1, 8'h04, 32'hFFFF_FFFF, 23'h3, "R9");
        chk_all("R9");

        // Random traffic against the model.
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] d;
            logic [7:0] a;
            op = $urandom_range(0, 9);
            d  = $urandom;
            a  = 8'(4 * $urandom_range(0, 5));
            if (op < 5) step(0, 0, 0, N'($urandom), "R2");
            else        step(1, a, d, line_in, "R8");
            chk_all("R8");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule